// File: doc/BRIEF.md
# Packet Store-and-Replay Link Buffer with Bit Error Injection

This block stands in for a serial storage device on a byte-oriented link. The link carries a word of two bytes each cycle, and each byte has a flag that marks it as a control character. On the receive side, the block waits for a start word. It then writes every plain data word of the packet into an internal FIFO, and it ignores idle comma words and any traffic outside a packet. Each stored entry carries a tag that marks the first word of a packet, so packet boundaries survive storage.

On a send request the transmit side replays the oldest stored packet. It sends a start word first, then the stored words on consecutive cycles, and returns to idle commas afterwards. At all other times it sends idle commas. A host-programmable corruption stage XORs a 16-bit mask into the word at a chosen offset of every replayed packet, so that a downstream error-correcting decoder can be exercised with known faults. A sticky flag records any word that was lost because the FIFO was full.

Top module: `serial_store`

## Requirements
- R1: After reset the transmit word is the idle word (data 16'hBCBC, flags 2'b11) and the overflow flag is 0.
- R2: Outside a packet, receive words are never stored. This covers idle words, flagged words other than the start word, and unflagged data words.
- R3: Capture begins on the start word, which is exactly data 16'hBCFB with flags 2'b11: the low byte 0xFB and the high byte 0xBC are both flagged as control characters.
- R4: During capture, each word with flags 2'b00 is stored in arrival order. Any other flagged word ends the packet. A start word received during capture closes the current packet and opens a new one.
- R5: Suppose send is high at a clock edge, the transmit side is idle, and the FIFO is not empty. Then the transmit word after that edge is the start word. On each following cycle the next stored word of the oldest packet appears with flags 2'b00. The idle word follows the last of them.
- R6: Send has no effect while the FIFO is empty or while a replay is in progress.
- R7: When errEnable is 1, the replayed word at zero-based offset errIndex within each packet is XORed with errMask. All other words are unchanged. If errEnable is 0, or errIndex is not less than the packet length, no word changes.
- R8: A data word that arrives while the FIFO holds DEPTH words is dropped. The overflow flag is then set and stays set until reset.
- R9: Several packets can be stored. Each send replays exactly one packet, and packets are replayed in arrival order.
- R10: The transmit side emits only three kinds of word: the idle word, the start word, and stored data words with flags 2'b00.
- R11: Receiving and replaying can proceed in the same cycles without losing or reordering words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 16 | Incoming link word |
| rxCharIsK | input | 2 | Per-byte control flag of rxData (bit i for byte i) |
| send | input | 1 | Request replay of the oldest stored packet |
| errEnable | input | 1 | Enables bit error injection |
| errMask | input | 16 | XOR mask applied to the chosen word |
| errIndex | input | 8 | Zero-based word offset within a packet to corrupt |
| txData | output | 16 | Outgoing link word |
| txCharIsK | output | 2 | Per-byte control flag of txData |
| overflow | output | 1 | Sticky FIFO overflow indication |

## Verification
On every cycle, the assertions check the following:
- the transmit side emits only idle, start or unflagged data words;
- a start word is always followed by a data word;
- overflow never clears once set;
- the control never pushes into a full FIFO or pops an empty one;
- the FIFO count stays within its depth.

Other properties need words traced end to end, so only the bench scenarios show them. These are the packet contents and ordering, framing by start words and by other control words, the corrupted offset and mask, the dropping of send requests, and overlapping receive and replay. The bench uses seeded random packets and directed framing corner cases for these.

// File: rtl/ss_pkg.sv
package ss_pkg;

  localparam logic [7:0] COMMA_CHAR = 8'hBC;
  localparam logic [7:0] START_CHAR = 8'hFB;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2
  } txSel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic   push;
    logic   pushFirst;
    logic   pop;
    logic   corrupt;
    txSel_e txSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ss_datapath.sv
module ss_datapath
  import ss_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 16,
  localparam int W  = 8 * LANES,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  rxData,
  input  ctrlStrobe_t   strobe,
  input  logic [W-1:0]  errMask,
  output logic [W-1:0]  txData,
  output logic [LANES-1:0] txCharIsK,
  output logic          fifoEmpty,
  output logic          fifoFull,
  output logic          headFirst,
  output logic [CW-1:0] fifoCount
);

  localparam logic [W-1:0] IDLE_WORD  = {LANES{COMMA_CHAR}};
  localparam logic [W-1:0] START_WORD = {{(LANES-1){COMMA_CHAR}}, START_CHAR};
  localparam logic [AW-1:0] LAST_PTR  = AW'(DEPTH - 1);

  logic [W-1:0]  memData  [DEPTH];
  logic          memFirst [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [W-1:0]  headData;
  logic [W-1:0]  nextData;
  logic [LANES-1:0] nextK;

  // storage array, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      memData[wrPtr]  <= rxData;
      memFirst[wrPtr] <= strobe.pushFirst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign fifoCount = count;
  assign headData  = memData[rdPtr];
  assign headFirst = memFirst[rdPtr];

  // transmit word selection with corruption stage
  always_comb begin
    nextData = IDLE_WORD;
    nextK    = '1;
    case (strobe.txSel)
      TX_START: begin
        nextData = START_WORD;
        nextK    = '1;
      end
      TX_DATA: begin
        nextData = strobe.corrupt ? (headData ^ errMask) : headData;
        nextK    = '0;
      end
      default: begin
        nextData = IDLE_WORD;
        nextK    = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData    <= IDLE_WORD;
      txCharIsK <= '1;
    end else begin
      txData    <= nextData;
      txCharIsK <= nextK;
    end
  end

endmodule

// File: rtl/ss_control.sv
module ss_control
  import ss_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IDX_W = 8,
  localparam int W = 8 * LANES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     rxData,
  input  logic [LANES-1:0] rxCharIsK,
  input  logic             send,
  input  logic             errEnable,
  input  logic [IDX_W-1:0] errIndex,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             headFirst,
  output ctrlStrobe_t      strobe,
  output logic             overflow
);

  localparam logic [W-1:0] START_WORD = {{(LANES-1){COMMA_CHAR}}, START_CHAR};
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic {RX_WAIT, RX_CAPTURE} rxState_e;
  typedef enum logic {TXS_IDLE, TXS_PLAY} txState_e;

  rxState_e rxState;
  txState_e txState;
  logic     pendFirst;
  logic [IDX_W-1:0] wordIdx;

  logic rxIsStart, rxIsData, wantStore, dropWord, canPop;

  // ---------------- receive side ----------------
  assign rxIsStart = (rxCharIsK == '1) && (rxData == START_WORD);
  assign rxIsData  = (rxCharIsK == '0);
  assign wantStore = (rxState == RX_CAPTURE) && rxIsData;
  assign dropWord  = wantStore && fifoFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_WAIT;
      pendFirst <= 1'b0;
    end else begin
      case (rxState)
        RX_WAIT: begin
          if (rxIsStart) begin
            rxState   <= RX_CAPTURE;
            pendFirst <= 1'b1;
          end
        end
        default: begin
          if (rxIsStart) begin
            pendFirst <= 1'b1;
          end else if (rxIsData) begin
            if (!fifoFull) pendFirst <= 1'b0;
          end else begin
            rxState <= RX_WAIT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        overflow <= 1'b0;
    else if (dropWord) overflow <= 1'b1;
  end

  // ---------------- transmit side ----------------
  assign canPop = !fifoEmpty && !(headFirst && (wordIdx != '0));

  always_comb begin
    strobe.push      = wantStore && !fifoFull;
    strobe.pushFirst = pendFirst;
    strobe.pop       = 1'b0;
    strobe.corrupt   = 1'b0;
    strobe.txSel     = TX_IDLE;
    case (txState)
      TXS_IDLE: begin
        if (send && !fifoEmpty) strobe.txSel = TX_START;
      end
      default: begin
        if (canPop) begin
          strobe.txSel   = TX_DATA;
          strobe.pop     = 1'b1;
          strobe.corrupt = errEnable && (wordIdx == errIndex);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TXS_IDLE;
      wordIdx <= '0;
    end else begin
      case (txState)
        TXS_IDLE: begin
          if (send && !fifoEmpty) begin
            txState <= TXS_PLAY;
            wordIdx <= '0;
          end
        end
        default: begin
          if (canPop) begin
            if (wordIdx != IDX_MAX) wordIdx <= wordIdx + 1'b1;
          end else begin
            txState <= TXS_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/serial_store.sv
module serial_store
  import ss_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  localparam int W  = 8 * LANES,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     rxData,
  input  logic [LANES-1:0] rxCharIsK,
  input  logic             send,
  input  logic             errEnable,
  input  logic [W-1:0]     errMask,
  input  logic [IDX_W-1:0] errIndex,
  output logic [W-1:0]     txData,
  output logic [LANES-1:0] txCharIsK,
  output logic             overflow
);

  ctrlStrobe_t   strobe;
  logic          fifoEmpty;
  logic          fifoFull;
  logic          headFirst;
  logic [CW-1:0] fifoCount;

  ss_control #(.LANES(LANES), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxData    (rxData),
    .rxCharIsK (rxCharIsK),
    .send      (send),
    .errEnable (errEnable),
    .errIndex  (errIndex),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .headFirst (headFirst),
    .strobe    (strobe),
    .overflow  (overflow)
  );

  ss_datapath #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxData    (rxData),
    .strobe    (strobe),
    .errMask   (errMask),
    .txData    (txData),
    .txCharIsK (txCharIsK),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .headFirst (headFirst),
    .fifoCount (fifoCount)
  );

endmodule

// File: rtl/ss_checker.sv
module ss_checker
  import ss_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 16,
  localparam int W  = 8 * LANES,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [W-1:0]     txData,
  input logic [LANES-1:0] txCharIsK,
  input logic             overflow,
  input ctrlStrobe_t      strobe,
  input logic             fifoEmpty,
  input logic             fifoFull,
  input logic [CW-1:0]    fifoCount
);

  localparam logic [W-1:0] IDLE_W  = {LANES{COMMA_CHAR}};
  localparam logic [W-1:0] START_W = {{(LANES-1){COMMA_CHAR}}, START_CHAR};

  logic txIsStart;
  assign txIsStart = (txCharIsK == '1) && (txData == START_W);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_tx_word_kinds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txCharIsK != '0) |-> ((txCharIsK == '1) && ((txData == IDLE_W) || (txData == START_W))));

  assert_start_then_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    txIsStart |=> (txCharIsK == '0));

  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !fifoFull);

  assert_no_pop_when_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !fifoEmpty);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

endmodule

bind serial_store ss_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txData    (txData),
  .txCharIsK (txCharIsK),
  .overflow  (overflow),
  .strobe    (strobe),
  .fifoEmpty (fifoEmpty),
  .fifoFull  (fifoFull),
  .fifoCount (fifoCount)
);

// File: tb/serial_store_tb.sv
module serial_store_tb;

  localparam int DEPTH = 16;
  localparam logic [15:0] IDLE_W  = 16'hBCBC;
  localparam logic [15:0] START_W = 16'hBCFB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] rxData = IDLE_W;
  logic [1:0]  rxK = 2'b11;
  logic        send = 1'b0;
  logic        errEn = 1'b0;
  logic [15:0] errMask = '0;
  logic [7:0]  errIdx = '0;
  logic [15:0] txData;
  logic [1:0]  txK;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  logic [15:0] modelQ[$];
  int          lenQ[$];
  int          modelCount = 0;

  always #4 clk = ~clk;

  serial_store #(.LANES(2), .DEPTH(DEPTH), .IDX_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxCharIsK(rxK), .send(send),
    .errEnable(errEn), .errMask(errMask), .errIndex(errIdx),
    .txData(txData), .txCharIsK(txK), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [15:0] w, input int idx);
    return (errEn && (idx == int'(errIdx))) ? (w ^ errMask) : w;
  endfunction

  task automatic putWord(input logic [15:0] d, input logic [1:0] k);
    rxData = d;
    rxK    = k;
    @(negedge clk);
  endtask

  // start word, len data words, idle; model keeps what fits
  task automatic writePacket(input int len);
    int stored = 0;
    putWord(START_W, 2'b11);
    for (int i = 0; i < len; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      putWord(w, 2'b00);
      if (modelCount < DEPTH) begin
        modelQ.push_back(w);
        modelCount++;
        stored++;
      end
    end
    putWord(IDLE_W, 2'b11);
    if (stored > 0) lenQ.push_back(stored);
  endtask

  task automatic replayCheck(input string req, input bit extraSend);
    int L;
    int got = 0;
    logic [15:0] exp[$];
    L = lenQ.pop_front();
    for (int i = 0; i < L; i++) exp.push_back(modelQ.pop_front());
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    check(txK == 2'b11 && txData == START_W, {req, " R5 start word"}, {14'd0, txK, txData}, {16'd3, START_W});
    for (int g = 0; g < 64; g++) begin
      @(negedge clk);
      send = 1'b0;
      if (txK != 2'b00) break;
      if (g < L) check(txData == expWord(exp[g], g), {req, " word"}, {16'd0, txData}, {16'd0, expWord(exp[g], g)});
      got++;
      if (extraSend && g == 1) send = 1'b1;
    end
    check(got == L, {req, " R10 length"}, got, L);
    check(txK == 2'b11 && txData == IDLE_W, {req, " R5 idle after"}, {14'd0, txK, txData}, {16'd3, IDLE_W});
    modelCount -= L;
  endtask

  task automatic checkIdleFor(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(txK == 2'b11 && txData == IDLE_W, req, {14'd0, txK, txData}, {16'd3, IDLE_W});
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txData == IDLE_W, "R1 txData", {16'd0, txData}, {16'd0, IDLE_W});
    check(txK == 2'b11, "R1 txCharIsK", {30'd0, txK}, 32'd3);
    check(overflow == 1'b0, "R1 overflow", {31'd0, overflow}, 32'd0);

    // R2: traffic outside packets is not stored
    putWord(IDLE_W, 2'b11);
    putWord(16'h1234, 2'b00);
    putWord(16'h00F7, 2'b01);
    putWord(16'hFBFB, 2'b11);
    putWord(16'hBEEF, 2'b00);
    putWord(IDLE_W, 2'b11);
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    check(txK == 2'b11 && txData == IDLE_W, "R2 R6 send with nothing stored", {14'd0, txK, txData}, {16'd3, IDLE_W});
    checkIdleFor(3, "R2 idle kept");

    // R3 R4 R5: random packets, no corruption
    for (int p = 0; p < 8; p++) begin
      writePacket(1 + int'($urandom_range(11)));
      replayCheck("R3 R4 random packet", 1'b0);
    end

    // R7: corruption at several offsets
    errEn = 1'b1;
    errMask = 16'h8001;
    errIdx = 8'd3;
    writePacket(8);
    replayCheck("R7 offset 3", 1'b0);
    errIdx = 8'd0;
    errMask = 16'($urandom) | 16'h0100;
    writePacket(5);
    replayCheck("R7 offset 0", 1'b0);
    errIdx = 8'd5;
    writePacket(6);
    replayCheck("R7 last word", 1'b0);
    errIdx = 8'd9;
    writePacket(4);
    replayCheck("R7 offset beyond length", 1'b0);
    errEn = 1'b0;
    errIdx = 8'd1;
    writePacket(4);
    replayCheck("R7 disabled", 1'b0);

    // R9: several stored, replayed in order; corruption applies per packet
    errEn = 1'b1;
    errIdx = 8'd1;
    errMask = 16'h00FF;
    writePacket(3);
    writePacket(5);
    writePacket(4);
    replayCheck("R9 first", 1'b0);
    replayCheck("R9 second", 1'b0);
    replayCheck("R9 third", 1'b0);
    errEn = 1'b0;

    // R4: start word inside capture and a foreign control word ending a packet
    putWord(START_W, 2'b11);
    putWord(16'hA001, 2'b00); putWord(16'hA002, 2'b00); putWord(16'hA003, 2'b00);
    putWord(START_W, 2'b11);
    putWord(16'hB001, 2'b00); putWord(16'hB002, 2'b00);
    putWord(16'h00F7, 2'b01);
    putWord(16'hC0DE, 2'b00);
    putWord(IDLE_W, 2'b11);
    modelQ.push_back(16'hA001); modelQ.push_back(16'hA002); modelQ.push_back(16'hA003);
    modelQ.push_back(16'hB001); modelQ.push_back(16'hB002);
    lenQ.push_back(3); lenQ.push_back(2);
    modelCount += 5;
    replayCheck("R4 split by start", 1'b0);
    replayCheck("R4 ended by control word", 1'b0);
    checkIdleFor(3, "R4 R2 word after end not stored");

    // R6: send during a replay is ignored
    writePacket(5);
    writePacket(3);
    replayCheck("R6 send during replay", 1'b1);
    checkIdleFor(4, "R6 no second replay");
    replayCheck("R6 later packet", 1'b0);

    // R11: receive while replaying
    writePacket(6);
    fork
      replayCheck("R11 replay", 1'b0);
      writePacket(5);
    join
    replayCheck("R11 packet received during replay", 1'b0);

    // R8: overflow drops words and sticks
    check(overflow == 1'b0, "R8 no overflow yet", {31'd0, overflow}, 32'd0);
    writePacket(DEPTH + 4);
    check(overflow == 1'b1, "R8 overflow set", {31'd0, overflow}, 32'd1);
    replayCheck("R8 first DEPTH words kept", 1'b0);
    checkIdleFor(2, "R8 dropped words absent");
    check(overflow == 1'b1, "R8 overflow sticky", {31'd0, overflow}, 32'd1);

    // R6: send with FIFO empty after draining
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    check(txK == 2'b11 && txData == IDLE_W, "R6 empty send", {14'd0, txK, txData}, {16'd3, IDLE_W});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule